// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps the coherence state for every line of one private cache that sits on a shared snooping bus. Each line is Invalid, Shared, Exclusive-clean or Modified. Processor reads, writes and evictions are resolved against this state. An access that the cache can settle by itself completes in the same cycle with no bus traffic. Any other access raises a bus request that carries the right command (read, read-for-ownership, upgrade or writeback), and the access finishes in the cycle the external arbiter grants it. The arbiter is outside this block.

On the other side, the block snoops the transactions that other caches place on the bus. A snooped read that hits a valid copy drives this cache's contribution to the wired-OR shared line. When this cache's own read miss is granted, it samples the shared line to choose the fill state. A low line means no other holder exists, so the line fills as Exclusive-clean, and a later write to it is silent. A high line fills it as Shared. A Modified holder always supplies data when it is snooped. When cache-to-cache supply is enabled, a clean copy supplies data on a snooped read only if no cache with a lower identifier is also asserting the shared line. This leaves exactly one data driver.

An address is split into a set index (low bits) and a tag (high bits). The store is direct-mapped, with one state and one tag per set.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. A snooped read asserts neither `snp_shared_out` nor `snp_flush`, and a processor read raises `bus_req` with `bus_cmd` = 1 (read) at the requested address.
- R2: When a read miss is granted, it completes (`cpu_done` = 1) in the grant cycle. The line fills as Exclusive-clean if `bus_shared_in` is 0 in that cycle and as Shared if it is 1.
- R3: A write to an Exclusive-clean or Modified line completes in the same cycle with `bus_req` = 0 and leaves the line Modified.
- R4: A write to a Shared line requests `bus_cmd` = 3 (upgrade). A write to an absent line requests `bus_cmd` = 2 (read-for-ownership). Either write completes on grant and leaves the line Modified.
- R5: A snooped read (`snp_cmd` = 1) that hits a valid line asserts `snp_shared_out` in that cycle. An Exclusive-clean or Modified line becomes Shared, and a Modified line also asserts `snp_flush`.
- R6: A snooped read-for-ownership (2) or upgrade (3) that hits invalidates the line without asserting `snp_shared_out`. A Modified line asserts `snp_flush` on read-for-ownership, and a clean line does not.
- R7: Eviction (`cpu_op` = 2) of a Modified line requests `bus_cmd` = 4 (writeback) and invalidates the line on grant. Eviction of a clean line completes at once with no bus request and invalidates the line.
- R8: A read or write miss whose set holds a Modified line with another tag first requests a writeback of that victim's address. On grant the victim becomes Invalid and the access stays pending.
- R9: With cache-to-cache supply enabled, a clean line hit by a snooped read asserts `snp_flush` only if no bit of `peer_shared` below `CACHE_ID` is set. This cache's own bit in `peer_shared` is ignored.
- R10: In a cycle with `snp_valid` = 1, no processor access completes and `bus_req` is 0. The snoop's state change takes effect alone.
- R11: A read that hits a line in any valid state completes in the same cycle with `bus_req` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access pending; held until `cpu_done` |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict, 3 completes with no effect |
| cpu_addr | input | IDX_W+TAG_W | Access address: tag in the high bits, set index in the low bits |
| cpu_done | output | 1 | Access completes at this clock edge |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 3 | 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback |
| bus_addr | output | IDX_W+TAG_W | Address of the requested transaction |
| bus_gnt | input | 1 | Arbiter grant; the transaction takes place in this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line from the other caches |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 3 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | IDX_W+TAG_W | Snooped address |
| peer_shared | input | NUM_CACHES | Shared-line contributions of all caches, by identifier |
| snp_shared_out | output | 1 | This cache's shared-line contribution |
| snp_flush | output | 1 | This cache drives the data for the snooped transaction |

## Verification
On every cycle, the assertions check these properties: the processor and snoop sides never update the store together, a silent write never raises the bus, the state filled after a granted read matches the sampled shared line, a hit by an invalidating snoop leaves the line Invalid, and the shared line is driven only on snooped reads. The bench scenarios are needed to show whole state histories, observed only through later accesses. These include Exclusive-clean turning into Shared when a peer reads, the victim writeback ordering before a conflicting fill, the silent drop of a clean eviction, and the choice of the single data driver under different patterns of peer shared lines.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHD = 2'd1,
    ST_EXC = 2'd2,
    ST_MOD = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_UPGR = 3'd3,
    BC_WB   = 3'd4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_EV  = 2'd2,
    OP_NOP = 2'd3
  } cpu_op_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic [TAG_W-1:0] cpu_tag,
  output line_st_e         cpu_st,
  input  logic [IDX_W-1:0] snp_idx,
  output logic [TAG_W-1:0] snp_tag,
  output line_st_e         snp_st,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_widx,
  input  logic [TAG_W-1:0] cpu_wtag,
  input  line_st_e         cpu_wst,
  input  logic             snp_we,
  input  logic [IDX_W-1:0] snp_widx,
  input  line_st_e         snp_wst
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [SETS];
  line_st_e         st_q  [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             set_en;
    logic [TAG_W-1:0] tag_d;
    line_st_e         st_d;

    always_comb begin
      set_en = 1'b0;
      tag_d  = tag_q[s];
      st_d   = st_q[s];
      if (cpu_we && cpu_widx == IDX_W'(s)) begin
        set_en = 1'b1;
        tag_d  = cpu_wtag;
        st_d   = cpu_wst;
      end else if (snp_we && snp_widx == IDX_W'(s)) begin
        set_en = 1'b1;
        st_d   = snp_wst;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[s] <= '0;
        st_q[s]  <= ST_INV;
      end else if (set_en) begin
        tag_q[s] <= tag_d;
        st_q[s]  <= st_d;
      end
    end
  end

  assign cpu_tag = tag_q[cpu_idx];
  assign cpu_st  = st_q[cpu_idx];
  assign snp_tag = tag_q[snp_idx];
  assign snp_st  = st_q[snp_idx];

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && snp_we)); // R10

endmodule

// File: rtl/mesi_cpu_side.sv
module mesi_cpu_side
  import mesi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic [1:0]             cpu_op,
  input  logic [IDX_W+TAG_W-1:0] cpu_addr,
  output logic                   cpu_done,
  input  logic [TAG_W-1:0]       line_tag,
  input  line_st_e               line_st,
  input  logic                   snp_valid,
  output logic                   bus_req,
  output logic [2:0]             bus_cmd,
  output logic [IDX_W+TAG_W-1:0] bus_addr,
  input  logic                   bus_gnt,
  input  logic                   bus_shared_in,
  output logic                   wr_en,
  output logic [TAG_W-1:0]       wr_tag,
  output line_st_e               wr_st
);
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             tag_hit, go, victim_dirty;
  bus_cmd_e         cmd;

  assign idx          = cpu_addr[IDX_W-1:0];
  assign tag          = cpu_addr[IDX_W+TAG_W-1:IDX_W];
  assign tag_hit      = (line_tag == tag) && (line_st != ST_INV);
  assign victim_dirty = (line_tag != tag) && (line_st == ST_MOD);
  assign go           = cpu_req && !snp_valid;

  always_comb begin
    cmd      = BC_NONE;
    bus_addr = cpu_addr;
    cpu_done = 1'b0;
    wr_en    = 1'b0;
    wr_tag   = line_tag;
    wr_st    = line_st;
    if (go) begin
      unique case (cpu_op_e'(cpu_op))
        OP_RD: begin
          if (tag_hit) begin
            cpu_done = 1'b1;
          end else if (victim_dirty) begin
            cmd      = BC_WB;
            bus_addr = {line_tag, idx};
            wr_en    = bus_gnt;
            wr_st    = ST_INV;
          end else begin
            cmd      = BC_RD;
            cpu_done = bus_gnt;
            wr_en    = bus_gnt;
            wr_tag   = tag;
            wr_st    = bus_shared_in ? ST_SHD : ST_EXC;
          end
        end
        OP_WR: begin
          if (tag_hit && line_st != ST_SHD) begin
            cpu_done = 1'b1;
            wr_en    = 1'b1;
            wr_st    = ST_MOD;
          end else if (tag_hit) begin
            cmd      = BC_UPGR;
            cpu_done = bus_gnt;
            wr_en    = bus_gnt;
            wr_st    = ST_MOD;
          end else if (victim_dirty) begin
            cmd      = BC_WB;
            bus_addr = {line_tag, idx};
            wr_en    = bus_gnt;
            wr_st    = ST_INV;
          end else begin
            cmd      = BC_RDX;
            cpu_done = bus_gnt;
            wr_en    = bus_gnt;
            wr_tag   = tag;
            wr_st    = ST_MOD;
          end
        end
        OP_EV: begin
          if (tag_hit && line_st == ST_MOD) begin
            cmd      = BC_WB;
            cpu_done = bus_gnt;
            wr_en    = bus_gnt;
            wr_st    = ST_INV;
          end else begin
            cpu_done = 1'b1;
            wr_en    = tag_hit;
            wr_st    = ST_INV;
          end
        end
        default: cpu_done = 1'b1;
      endcase
    end
  end

  assign bus_req = (cmd != BC_NONE);
  assign bus_cmd = cmd;

  AST_SILENT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !snp_valid && cpu_op == OP_WR && tag_hit && line_st == ST_EXC)
      |-> (!bus_req && cpu_done)); // R3

  AST_FILL_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == BC_RD && !bus_shared_in)
      |=> (cpu_addr != $past(cpu_addr) || line_st == ST_EXC)); // R2

  AST_FILL_SHD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == BC_RD && bus_shared_in)
      |=> (cpu_addr != $past(cpu_addr) || line_st == ST_SHD)); // R2

  AST_SNOOP_BLOCKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!bus_req && !cpu_done)); // R10

endmodule

// File: rtl/mesi_snoop_side.sv
module mesi_snoop_side
  import mesi_pkg::*;
#(
  parameter int IDX_W      = 2,
  parameter int TAG_W      = 4,
  parameter int NUM_CACHES = 4,
  parameter int CACHE_ID   = 1,
  parameter bit C2C_EN     = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   snp_valid,
  input  logic [2:0]             snp_cmd,
  input  logic [IDX_W+TAG_W-1:0] snp_addr,
  input  logic [NUM_CACHES-1:0]  peer_shared,
  input  logic [TAG_W-1:0]       line_tag,
  input  line_st_e               line_st,
  output logic                   snp_shared_out,
  output logic                   snp_flush,
  output logic                   wr_en,
  output line_st_e               wr_st
);
  localparam logic [NUM_CACHES-1:0] LOWER_MASK =
    NUM_CACHES'((64'd1 << CACHE_ID) - 64'd1);

  logic hit, lower_peer;

  assign hit        = snp_valid && (line_st != ST_INV) &&
                      (line_tag == snp_addr[IDX_W+TAG_W-1:IDX_W]);
  assign lower_peer = |(peer_shared & LOWER_MASK);

  always_comb begin
    snp_shared_out = 1'b0;
    snp_flush      = 1'b0;
    wr_st          = line_st;
    if (hit) begin
      unique case (bus_cmd_e'(snp_cmd))
        BC_RD: begin
          snp_shared_out = 1'b1;
          wr_st          = ST_SHD;
          if (line_st == ST_MOD)
            snp_flush = 1'b1;
          else if (C2C_EN)
            snp_flush = !lower_peer;
        end
        BC_RDX: begin
          wr_st     = ST_INV;
          snp_flush = (line_st == ST_MOD);
        end
        BC_UPGR: wr_st = ST_INV;
        default: wr_st = line_st;
      endcase
    end
  end

  assign wr_en = hit && (wr_st != line_st);

  AST_SHARED_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared_out |-> (snp_valid && snp_cmd == BC_RD)); // R5

  AST_INVAL_AFTER_RDX: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (snp_cmd == BC_RDX || snp_cmd == BC_UPGR))
      |=> (snp_addr != $past(snp_addr) || line_st == ST_INV)); // R6

  AST_FLUSH_NEEDS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && line_st != ST_INV)); // R9

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int IDX_W      = 2,
  parameter int TAG_W      = 4,
  parameter int NUM_CACHES = 4,
  parameter int CACHE_ID   = 1,
  parameter bit C2C_EN     = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic [1:0]             cpu_op,
  input  logic [IDX_W+TAG_W-1:0] cpu_addr,
  output logic                   cpu_done,
  output logic                   bus_req,
  output logic [2:0]             bus_cmd,
  output logic [IDX_W+TAG_W-1:0] bus_addr,
  input  logic                   bus_gnt,
  input  logic                   bus_shared_in,
  input  logic                   snp_valid,
  input  logic [2:0]             snp_cmd,
  input  logic [IDX_W+TAG_W-1:0] snp_addr,
  input  logic [NUM_CACHES-1:0]  peer_shared,
  output logic                   snp_shared_out,
  output logic                   snp_flush
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [TAG_W-1:0] c_tag, s_tag, c_wtag;
  line_st_e         c_st, s_st, c_wst, s_wst;
  logic             c_we, s_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_int_n),
    .cpu_idx(cpu_addr[IDX_W-1:0]), .cpu_tag(c_tag), .cpu_st(c_st),
    .snp_idx(snp_addr[IDX_W-1:0]), .snp_tag(s_tag), .snp_st(s_st),
    .cpu_we(c_we), .cpu_widx(cpu_addr[IDX_W-1:0]), .cpu_wtag(c_wtag), .cpu_wst(c_wst),
    .snp_we(s_we), .snp_widx(snp_addr[IDX_W-1:0]), .snp_wst(s_wst)
  );

  mesi_cpu_side #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_cpu (
    .clk(clk), .rst_n(rst_int_n),
    .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_done(cpu_done),
    .line_tag(c_tag), .line_st(c_st), .snp_valid(snp_valid),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .wr_en(c_we), .wr_tag(c_wtag), .wr_st(c_wst)
  );

  mesi_snoop_side #(.IDX_W(IDX_W), .TAG_W(TAG_W), .NUM_CACHES(NUM_CACHES),
                    .CACHE_ID(CACHE_ID), .C2C_EN(C2C_EN)) u_snp (
    .clk(clk), .rst_n(rst_int_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .peer_shared(peer_shared), .line_tag(s_tag), .line_st(s_st),
    .snp_shared_out(snp_shared_out), .snp_flush(snp_flush),
    .wr_en(s_we), .wr_st(s_wst)
  );

  AST_DONE_NOT_WITH_SNOOP: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_done |-> !snp_valid); // R10

endmodule

// File: tb/mesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_req, bus_gnt, bus_shared_in, snp_valid;
  logic [1:0] cpu_op;
  logic [5:0] cpu_addr, snp_addr, bus_addr;
  logic [2:0] snp_cmd, bus_cmd;
  logic [3:0] peer_shared;
  logic       cpu_done, bus_req, snp_shared_out, snp_flush;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mesi_snoop_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .peer_shared(peer_shared), .snp_shared_out(snp_shared_out), .snp_flush(snp_flush)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic rq, input logic [1:0] op, input logic [5:0] a,
                      input logic g, input logic sh, input logic sv,
                      input logic [2:0] sc, input logic [5:0] sa, input logic [3:0] pr);
    @(negedge clk);
    cpu_req = rq; cpu_op = op; cpu_addr = a; bus_gnt = g; bus_shared_in = sh;
    snp_valid = sv; snp_cmd = sc; snp_addr = sa; peer_shared = pr;
    #1;
  endtask

  task automatic cpu(input logic [1:0] op, input logic [5:0] a, input logic g, input logic sh);
    step(1'b1, op, a, g, sh, 1'b0, 3'd0, 6'd0, 4'd0);
  endtask

  task automatic snoop(input logic [2:0] sc, input logic [5:0] sa, input logic [3:0] pr);
    step(1'b0, 2'd0, 6'd0, 1'b0, 1'b0, 1'b1, sc, sa, pr);
  endtask

  task automatic expect_bus(input string r, input int rq, input int cmd, input int a, input int dn);
    chk(r, "bus_req", int'(bus_req), rq);
    if (rq != 0) begin
      chk(r, "bus_cmd", int'(bus_cmd), cmd);
      chk(r, "bus_addr", int'(bus_addr), a);
    end
    chk(r, "cpu_done", int'(cpu_done), dn);
  endtask

  task automatic expect_snp(input string r, input int sh, input int fl);
    chk(r, "snp_shared_out", int'(snp_shared_out), sh);
    chk(r, "snp_flush", int'(snp_flush), fl);
  endtask

  task automatic t_reset;
    snoop(3'd1, 6'h05, 4'd0);           expect_snp("R1", 0, 0);
    cpu(2'd0, 6'h05, 1'b0, 1'b0);       expect_bus("R1", 1, 1, 'h05, 0);
  endtask

  task automatic t_exclusive;
    cpu(2'd0, 6'h05, 1'b1, 1'b0);       expect_bus("R2", 1, 1, 'h05, 1);
    cpu(2'd1, 6'h05, 1'b0, 1'b0);       expect_bus("R3", 0, 0, 0, 1);
    cpu(2'd0, 6'h05, 1'b0, 1'b0);       expect_bus("R11", 0, 0, 0, 1);
    cpu(2'd2, 6'h05, 1'b0, 1'b0);       expect_bus("R7", 1, 4, 'h05, 0);
    cpu(2'd2, 6'h05, 1'b1, 1'b0);       expect_bus("R7", 1, 4, 'h05, 1);
    cpu(2'd0, 6'h05, 1'b0, 1'b0);       expect_bus("R7", 1, 1, 'h05, 0);
  endtask

  task automatic t_shared;
    cpu(2'd0, 6'h06, 1'b1, 1'b1);       expect_bus("R2", 1, 1, 'h06, 1);
    cpu(2'd1, 6'h06, 1'b0, 1'b0);       expect_bus("R4", 1, 3, 'h06, 0);
    cpu(2'd1, 6'h06, 1'b1, 1'b0);       expect_bus("R4", 1, 3, 'h06, 1);
    cpu(2'd1, 6'h06, 1'b0, 1'b0);       expect_bus("R3", 0, 0, 0, 1);
    snoop(3'd1, 6'h06, 4'd0);           expect_snp("R5", 1, 1);
    cpu(2'd1, 6'h06, 1'b0, 1'b0);       expect_bus("R5", 1, 3, 'h06, 0);
    snoop(3'd2, 6'h06, 4'd0);           expect_snp("R6", 0, 0);
    cpu(2'd1, 6'h06, 1'b0, 1'b0);       expect_bus("R6", 1, 2, 'h06, 0);
  endtask

  task automatic t_single_flusher;
    cpu(2'd0, 6'h08, 1'b1, 1'b0);       expect_bus("R2", 1, 1, 'h08, 1);
    snoop(3'd1, 6'h08, 4'b0001);        expect_snp("R9", 1, 0);
    cpu(2'd1, 6'h08, 1'b0, 1'b0);       expect_bus("R5", 1, 3, 'h08, 0);
    snoop(3'd1, 6'h08, 4'b1100);        expect_snp("R9", 1, 1);
    snoop(3'd1, 6'h08, 4'b0010);        expect_snp("R9", 1, 1);
    snoop(3'd3, 6'h08, 4'd0);           expect_snp("R6", 0, 0);
    cpu(2'd0, 6'h08, 1'b0, 1'b0);       expect_bus("R6", 1, 1, 'h08, 0);
  endtask

  task automatic t_victim;
    cpu(2'd1, 6'h0B, 1'b1, 1'b0);       expect_bus("R4", 1, 2, 'h0B, 1);
    cpu(2'd0, 6'h0F, 1'b0, 1'b0);       expect_bus("R8", 1, 4, 'h0B, 0);
    cpu(2'd0, 6'h0F, 1'b1, 1'b0);       expect_bus("R8", 1, 4, 'h0B, 0);
    cpu(2'd0, 6'h0F, 1'b0, 1'b0);       expect_bus("R8", 1, 1, 'h0F, 0);
    cpu(2'd0, 6'h0F, 1'b1, 1'b0);       expect_bus("R8", 1, 1, 'h0F, 1);
    snoop(3'd1, 6'h0B, 4'd0);           expect_snp("R8", 0, 0);
    cpu(2'd2, 6'h0F, 1'b0, 1'b0);       expect_bus("R7", 0, 0, 0, 1);
    cpu(2'd0, 6'h0F, 1'b0, 1'b0);       expect_bus("R7", 1, 1, 'h0F, 0);
  endtask

  task automatic t_snoop_priority;
    cpu(2'd1, 6'h05, 1'b1, 1'b0);       expect_bus("R4", 1, 2, 'h05, 1);
    step(1'b1, 2'd1, 6'h05, 1'b0, 1'b0, 1'b1, 3'd1, 6'h05, 4'd0);
    expect_bus("R10", 0, 0, 0, 0);
    expect_snp("R10", 1, 1);
    cpu(2'd1, 6'h05, 1'b0, 1'b0);       expect_bus("R10", 1, 3, 'h05, 0);
  endtask

  task automatic t_modified_rdx;
    cpu(2'd1, 6'h06, 1'b1, 1'b0);       expect_bus("R4", 1, 2, 'h06, 1);
    snoop(3'd2, 6'h06, 4'd0);           expect_snp("R6", 0, 1);
    cpu(2'd0, 6'h06, 1'b0, 1'b0);       expect_bus("R6", 1, 1, 'h06, 0);
  endtask

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_op = 2'd0; cpu_addr = 6'd0;
    bus_gnt = 1'b0; bus_shared_in = 1'b0; snp_valid = 1'b0;
    snp_cmd = 3'd0; snp_addr = 6'd0; peer_shared = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_exclusive;
    t_shared;
    t_single_flusher;
    t_victim;
    t_snoop_priority;
    t_modified_rdx;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule